// File: doc/BRIEF.md
# Bus Parity Generator and Checker

This block handles even parity for a synchronous parallel bus agent that moves a 32-bit address/data word and a 4-bit command/byte-enable word in each cycle. When the agent drives the bus, the block produces the parity bit one clock after the word it protects. The parity bit leaves through an output enable that trails the agent's drive request by one clock. When the agent receives data, the block registers the parity it expects. It then compares that value with the parity bit sampled on the next clock. A mismatch drives an active-low error strobe two clocks after the data phase.

Only data phases are checked. A data phase is a cycle in which both handshake strobes were sampled asserted, and a qualifier input reports this to the block. A sticky status bit records every mismatch. The status bit is set whether or not error reporting is enabled, and a one-cycle clear pulse resets it. Fault injection inverts the outgoing parity bit so that the error paths in a partner can be tested. Injection can be held on for the write data the agent sends as initiator, or for the read data it returns as target. A single-shot arm input corrupts exactly one driven data phase.

Top module: `parity_guard`

## Requirements
- R1: After reset, par_oe_o is 0, par_o is 0, perr_n_o is 1 and perr_sts_o is 0.
- R2: For every cycle in which drive_i is 1 and no injection applies, par_o in the following cycle makes the number of ones across ad_i, cbe_i and par_o even.
- R3: par_oe_o equals the value drive_i had one clock earlier.
- R4: A data phase is received when xfer_i is 1 and drive_i is 0 in cycle N. If par_i in cycle N+1 differs from the even-parity value and resp_en_i is 1 in cycle N+1, then perr_n_o is 0 for exactly cycle N+2.
- R5: With resp_en_i at 0 in cycle N+1, a parity mismatch leaves perr_n_o at 1, but perr_sts_o still becomes 1 in cycle N+2.
- R6: perr_sts_o stays 1 once set and returns to 0 in the cycle after a clr_i pulse. A mismatch that lands in the same cycle as a clr_i pulse keeps the bit at 1.
- R7: Cycles with xfer_i at 0, and cycles in which the block drives (drive_i at 1), are never checked. Any par_i value that follows such a cycle leaves perr_n_o and perr_sts_o unchanged.
- R8: While inj_wr_i is 1 and role_init_i is 1 (agent is initiator), the PAR for every driven data phase is inverted. While inj_rd_i is 1 and role_init_i is 0 (agent is target), the same inversion applies. inj_wr_i has no effect as target, and inj_rd_i has no effect as initiator.
- R9: A pulse on inj_once_i arms a single inversion. The inversion is applied to the first driven data phase after the pulse, in either role, and is then consumed.
- R10: A driven cycle with xfer_i at 0 (address phase) is never inverted, whatever the injection inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| ad_i | input | 32 | Address/data word for this cycle |
| cbe_i | input | 4 | Command/byte-enable word for this cycle |
| xfer_i | input | 1 | Both handshake strobes were sampled asserted (data phase) |
| drive_i | input | 1 | The agent drives AD and C/BE in this cycle |
| role_init_i | input | 1 | 1 = agent is initiator (write data), 0 = target (read data) |
| par_i | input | 1 | Parity bit sampled from the bus |
| resp_en_i | input | 1 | Enables reporting on perr_n_o |
| inj_wr_i | input | 1 | Held fault injection for initiator write data |
| inj_rd_i | input | 1 | Held fault injection for target read data |
| inj_once_i | input | 1 | Pulse that arms a one-shot parity inversion |
| clr_i | input | 1 | Write-one-to-clear pulse for the sticky status |
| par_o | output | 1 | Generated parity bit |
| par_oe_o | output | 1 | Output enable for par_o |
| perr_n_o | output | 1 | Data parity error strobe, active low |
| perr_sts_o | output | 1 | Sticky detected-parity-error status |

## Verification
A wrong stored expected-parity bit shows up on perr_n_o and perr_sts_o two clocks after the received data phase, because the comparison happens one clock later and then goes through a register. A wrong pipeline on the transmit side shows up on par_o one clock after the driven cycle. A one-shot arm flag that stays set shows up on the second driven data phase after the pulse as a second corrupted PAR. A role decode with the two controls swapped shows up the first time injection is held in the other role.

// File: rtl/pg_pkg.sv
package pg_pkg;

    typedef struct packed {
        logic par;
        logic oe;
        logic armed;
    } tx_st_t;

    typedef struct packed {
        logic exp_par;
        logic chk;
        logic perr;
        logic sts;
    } rx_st_t;

endpackage

// File: rtl/pg_xor_tree.sv
module pg_xor_tree #(
    parameter int W = 36
) (
    input  logic [W-1:0] vec_i,
    output logic         par_o
);
    localparam int LANES = (W + 7) / 8;

    logic [LANES-1:0] lane_par;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        localparam int LO = i * 8;
        localparam int HI = ((i * 8 + 8) > W) ? (W - 1) : (i * 8 + 7);
        assign lane_par[i] = ^vec_i[HI:LO];
    end

    assign par_o = ^lane_par;

endmodule

// File: rtl/pg_tx.sv
module pg_tx
    import pg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic calc_par_i,
    input  logic drive_i,
    input  logic xfer_i,
    input  logic role_init_i,
    input  logic inj_wr_i,
    input  logic inj_rd_i,
    input  logic inj_once_i,
    output logic par_o,
    output logic par_oe_o
);
    tx_st_t q, d;
    logic   data_drv;
    logic   held_inj;
    logic   flip;

    always_comb begin
        data_drv = drive_i & xfer_i;
        held_inj = role_init_i ? inj_wr_i : inj_rd_i;
        flip     = data_drv & (q.armed | held_inj);
        d        = q;
        d.par    = calc_par_i ^ flip;
        d.oe     = drive_i;
        d.armed  = inj_once_i | (q.armed & ~data_drv);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign par_o    = q.par;
    assign par_oe_o = q.oe;

    // R10: address phases are never corrupted
    a_r10_addr_clean: assert property (@(posedge clk) disable iff (!rst_n)
        (drive_i && !xfer_i) |=> (par_o == $past(calc_par_i)));

    // R8: held initiator injection inverts driven write data
    a_r8_wr_inject: assert property (@(posedge clk) disable iff (!rst_n)
        (drive_i && xfer_i && role_init_i && inj_wr_i) |=> (par_o != $past(calc_par_i)));

    // R9: the one-shot arm is consumed by a driven data phase
    a_r9_once_consumed: assert property (@(posedge clk) disable iff (!rst_n)
        (q.armed && drive_i && xfer_i && !inj_once_i) |=> !q.armed);

endmodule

// File: rtl/pg_rx.sv
module pg_rx
    import pg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic calc_par_i,
    input  logic drive_i,
    input  logic xfer_i,
    input  logic par_i,
    input  logic resp_en_i,
    input  logic clr_i,
    output logic perr_n_o,
    output logic sts_o
);
    rx_st_t q, d;
    logic   mismatch;

    always_comb begin
        mismatch  = q.chk & (par_i != q.exp_par);
        d         = q;
        d.exp_par = calc_par_i;
        d.chk     = xfer_i & ~drive_i;
        d.perr    = mismatch & resp_en_i;
        d.sts     = (q.sts & ~clr_i) | mismatch;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign perr_n_o = ~q.perr;
    assign sts_o    = q.sts;

    // R4: an error strobe only follows a checked data phase
    a_r4_perr_from_check: assert property (@(posedge clk) disable iff (!rst_n)
        q.perr |-> $past(q.chk));

    // R5: the error strobe needs the response enable
    a_r5_perr_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
        q.perr |-> $past(resp_en_i));

    // R6: a reported error is always recorded in the sticky bit
    a_r6_sticky_with_perr: assert property (@(posedge clk) disable iff (!rst_n)
        q.perr |-> q.sts);

    // R4: the strobe lasts a single clock per bad data phase
    a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (q.perr && !q.chk) |=> !q.perr);

endmodule

// File: rtl/parity_guard.sv
module parity_guard #(
    parameter int DATA_W = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [DATA_W-1:0]     ad_i,
    input  logic [DATA_W/8-1:0]   cbe_i,
    input  logic                  xfer_i,
    input  logic                  drive_i,
    input  logic                  role_init_i,
    input  logic                  par_i,
    input  logic                  resp_en_i,
    input  logic                  inj_wr_i,
    input  logic                  inj_rd_i,
    input  logic                  inj_once_i,
    input  logic                  clr_i,
    output logic                  par_o,
    output logic                  par_oe_o,
    output logic                  perr_n_o,
    output logic                  perr_sts_o
);
    localparam int BE_W  = DATA_W / 8;
    localparam int COV_W = DATA_W + BE_W;

    logic calc_par;

    pg_xor_tree #(.W(COV_W)) u_tree (
        .vec_i ({cbe_i, ad_i}),
        .par_o (calc_par)
    );

    pg_tx u_tx (
        .clk         (clk),
        .rst_n       (rst_n),
        .calc_par_i  (calc_par),
        .drive_i     (drive_i),
        .xfer_i      (xfer_i),
        .role_init_i (role_init_i),
        .inj_wr_i    (inj_wr_i),
        .inj_rd_i    (inj_rd_i),
        .inj_once_i  (inj_once_i),
        .par_o       (par_o),
        .par_oe_o    (par_oe_o)
    );

    pg_rx u_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .calc_par_i (calc_par),
        .drive_i    (drive_i),
        .xfer_i     (xfer_i),
        .par_i      (par_i),
        .resp_en_i  (resp_en_i),
        .clr_i      (clr_i),
        .perr_n_o   (perr_n_o),
        .sts_o      (perr_sts_o)
    );

    // R2: address-phase PAR makes the covered ones count even
    a_r2_even_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (drive_i && !xfer_i) |=> ((^{$past(cbe_i), $past(ad_i), par_o}) == 1'b0));

    // R3: the output enable only rises after a drive request
    a_r3_oe_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(par_oe_o) |-> $past(drive_i));

endmodule

// File: tb/parity_guard_test.sv
module parity_guard_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] ad = '0;
    logic [3:0]  cbe = '0;
    logic xfer = 0, drive = 0, role = 0, par_in = 0, resp = 0;
    logic inj_wr = 0, inj_rd = 0, once = 0, clr = 0;
    logic par_o, par_oe, perr_n, sts;

    int checks = 0, fails = 0;
    bit done = 0;

    // model state: value expected after the coming clock edge
    logic m_par = 0, m_oe = 0, m_exp = 0, m_chk = 0, m_perr = 0, m_sts = 0, m_armed = 0;

    always #5 clk = ~clk;

    parity_guard uut (
        .clk(clk), .rst_n(rst_n), .ad_i(ad), .cbe_i(cbe), .xfer_i(xfer),
        .drive_i(drive), .role_init_i(role), .par_i(par_in), .resp_en_i(resp),
        .inj_wr_i(inj_wr), .inj_rd_i(inj_rd), .inj_once_i(once), .clr_i(clr),
        .par_o(par_o), .par_oe_o(par_oe), .perr_n_o(perr_n), .perr_sts_o(sts)
    );

    task automatic check(string tag, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic even_par(logic [31:0] a, logic [3:0] c);
        return ^{c, a};
    endfunction

    // compare current outputs, then apply new inputs and advance model
    task automatic step(logic [31:0] a, logic [3:0] c, logic x, logic dr, logic r,
                        logic p, logic en, logic iw, logic ir, logic on, logic cl);
        logic flip, mism, dd;
        @(negedge clk);
        check("R2/R8/R9 par", par_o, m_par);
        check("R3 oe", par_oe, m_oe);
        check("R4/R5 perr_n", perr_n, ~m_perr);
        check("R6 sticky", sts, m_sts);
        ad = a; cbe = c; xfer = x; drive = dr; role = r; par_in = p; resp = en;
        inj_wr = iw; inj_rd = ir; once = on; clr = cl;
        dd     = dr & x;
        flip   = dd & (m_armed | (r ? iw : ir));
        mism   = m_chk & (p != m_exp);
        m_perr = mism & en;
        m_sts  = (m_sts & ~cl) | mism;
        m_par  = even_par(a, c) ^ flip;
        m_oe   = dr;
        m_exp  = even_par(a, c);
        m_chk  = x & ~dr;
        m_armed = on | (m_armed & ~dd);
    endtask

    task automatic idle();
        step('0, '0, 0, 0, 0, 0, 1, 0, 0, 0, 0);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] a;
        logic [3:0]  c;
        logic        x, dr, p;
        process::self().srandom(32'd1234);
        repeat (3) @(negedge clk);
        // R1: reset values
        check("R1 par", par_o, 1'b0);
        check("R1 oe", par_oe, 1'b0);
        check("R1 perr_n", perr_n, 1'b1);
        check("R1 sticky", sts, 1'b0);
        rst_n = 1'b1;

        // R2: driven address word, PAR next cycle
        step(32'h8000_0010, 4'hB, 0, 1, 1, 0, 1, 1, 1, 0, 0);
        step('0, '0, 0, 0, 0, 0, 1, 0, 0, 0, 0);
        check("R10 addr phase clean", par_o, even_par(32'h8000_0010, 4'hB));
        check("R3 oe after drive", par_oe, 1'b1);

        // R8: held write injection as initiator
        step(32'h1111_1111, 4'h0, 1, 1, 1, 0, 1, 1, 0, 0, 0);
        step('0, '0, 0, 0, 0, 0, 1, 0, 0, 0, 0);
        check("R8 write inverted", par_o, ~even_par(32'h1111_1111, 4'h0));
        // R8: inj_wr has no effect as target
        step(32'h0F0F_0001, 4'h3, 1, 1, 0, 0, 1, 1, 0, 0, 0);
        step('0, '0, 0, 0, 0, 0, 1, 0, 0, 0, 0);
        check("R8 inj_wr ignored as target", par_o, even_par(32'h0F0F_0001, 4'h3));
        step(32'h0F0F_0001, 4'h3, 1, 1, 0, 0, 1, 0, 1, 0, 0);
        step('0, '0, 0, 0, 0, 0, 1, 0, 0, 0, 0);
        check("R8 read inverted", par_o, ~even_par(32'h0F0F_0001, 4'h3));

        // R9: one-shot injection
        step('0, '0, 0, 0, 0, 0, 1, 0, 0, 1, 0);
        step(32'hA5A5_0000, 4'h1, 1, 1, 1, 0, 1, 0, 0, 0, 0);
        step(32'hA5A5_0000, 4'h1, 1, 1, 1, 0, 1, 0, 0, 0, 0);
        check("R9 first phase inverted", par_o, ~even_par(32'hA5A5_0000, 4'h1));
        step('0, '0, 0, 0, 0, 0, 1, 0, 0, 0, 0);
        check("R9 second phase clean", par_o, even_par(32'hA5A5_0000, 4'h1));

        // R4: received bad phase, strobe at N+2 for one clock
        step(32'h8f54_8f53, 4'h0, 1, 0, 1, 0, 1, 0, 0, 0, 0);
        step('0, '0, 0, 0, 0, ~even_par(32'h8f54_8f53, 4'h0), 1, 0, 0, 0, 0);
        idle();
        check("R4 perr low at N+2", perr_n, 1'b0);
        idle();
        check("R4 perr single clock", perr_n, 1'b1);
        // R6: clear
        step('0, '0, 0, 0, 0, 0, 1, 0, 0, 0, 1);
        idle();
        check("R6 cleared", sts, 1'b0);

        // R5: response disabled
        step(32'h0000_0007, 4'h0, 1, 0, 1, 0, 1, 0, 0, 0, 0);
        step('0, '0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        idle();
        check("R5 no strobe", perr_n, 1'b1);
        check("R5 sticky set", sts, 1'b1);
        // R6: clear coinciding with new mismatch keeps bit
        step(32'h0000_0001, 4'h0, 1, 0, 1, 0, 1, 0, 0, 0, 0);
        step('0, '0, 0, 0, 0, 0, 1, 0, 0, 0, 1);
        idle();
        check("R6 set wins over clear", sts, 1'b1);
        step('0, '0, 0, 0, 0, 0, 1, 0, 0, 0, 1);
        idle();

        // R7: own drive and non-data cycles are not checked
        step(32'h0000_0001, 4'h0, 1, 1, 1, 0, 1, 0, 0, 0, 0);
        step(32'h0000_0001, 4'h0, 0, 0, 1, 0, 1, 0, 0, 0, 0);
        step('0, '0, 0, 0, 0, 1, 1, 0, 0, 0, 0);
        idle();
        check("R7 no strobe", perr_n, 1'b1);
        check("R7 no sticky", sts, 1'b0);

        // random traffic
        for (int i = 0; i < 3000; i++) begin
            a  = $urandom;
            c  = 4'($urandom);
            x  = 1'($urandom);
            dr = 1'($urandom);
            p  = ($urandom_range(0, 3) == 0) ? ~m_exp : m_exp;
            step(a, c, x, dr, 1'($urandom), p, ($urandom_range(0, 3) != 0),
                 ($urandom_range(0, 5) == 0), ($urandom_range(0, 5) == 0),
                 ($urandom_range(0, 15) == 0), ($urandom_range(0, 7) == 0));
        end
        idle();
        idle();
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule